// File: doc/BRIEF.md
# Serial EEPROM Write and Busy-Poll Controller

This block is a host-side master for a 3-wire serial EEPROM. It drives chip select, serial clock and serial data, and it watches the device's data-out line. It takes one request at a time from a simple valid/op/address/data interface. The request can be a single-word write, a single-word erase, a fill of the whole array with one word, or a wipe of the whole array. The block shifts the command frame out and commits it by dropping chip select. It then runs the busy/ready verify phase until the device reports ready or a time limit runs out.

Before the first write-class command after reset, the block sends the write-unlock frame to the device without being asked. The serial clock half-period is set in system clocks by `clk_div`. During verify, polling can hold chip select high until data-out rises. It can also drop chip select after each busy sample and wait `poll_gap` clocks before it samples again, so the shared wires stay free for other work. The requester sees `busy` for the whole operation, then a one-cycle `done` pulse or a one-cycle `timeout` pulse.

Top module: `eep_wr_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `eep_cs`, `eep_sk`, `eep_di`, `busy`, `done` and `timeout` are all low.
- R2: A request is taken when `req_valid` is high while `busy` is low. `busy` is high from the next cycle until the cycle in which `done` or `timeout` pulses, and in that cycle `busy` is low.
- R3: Each frame is sent most significant bit first: a start bit 1, two opcode bits, an address field of ADDR_W bits, then DATA_W data bits for the data-carrying commands. The `req_op` codes and their frames are: 0 = write `1 01 addr data`; 1 = erase `1 11 addr`; 2 = fill `1 00 01 0..0 data`; 3 = wipe `1 00 10 0..0`. The unlock frame is `1 00 11 0..0`.
- R4: `eep_sk` high time is exactly `clk_div` clocks, and `eep_di` never changes in the cycle in which `eep_sk` rises.
- R5: The first request after reset is preceded by the unlock frame. Later requests send only their own frame.
- R6: `eep_sk` is low when `eep_cs` falls. Every low interval of `eep_cs` between two high intervals lasts at least 2*`clk_div` clocks.
- R7: During verify, whenever `eep_cs` is high, `eep_di` and `eep_sk` are low.
- R8: With `poll_suspend` = 0, verify uses a single `eep_cs` high interval that ends once `eep_do` is seen high.
- R9: With `poll_suspend` = 1, each busy sample (`eep_do` low) is followed by `eep_cs` low for at least `poll_gap` clocks before the next sample. A long busy time therefore gives several clock-free `eep_cs` high intervals.
- R10: When `eep_do` is seen high during verify, `eep_cs` drops and `done` pulses for exactly one cycle.
- R11: If ready is not seen within TMO_CYC clocks of the commit, `timeout` pulses for one cycle, `eep_cs` goes low and `done` does not pulse for that request.
- R12: A `req_valid` raised while `busy` is high is ignored: no frame is sent for it, and the latched request does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 3 | Command code (0 write, 1 erase, 2 fill, 3 wipe) |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Write or fill data |
| clk_div | input | DIV_W | Serial clock half-period in clocks, at least 1 |
| poll_suspend | input | 1 | 0: hold chip select during verify; 1: drop and retry |
| poll_gap | input | GAP_W | Extra chip-select-low clocks between suspended polls |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the device reports ready |
| timeout | output | 1 | One-cycle pulse when ready is not seen in time |
| eep_cs | output | 1 | Chip select to the device |
| eep_sk | output | 1 | Serial clock to the device |
| eep_di | output | 1 | Serial data to the device |
| eep_do | input | 1 | Device data-out (busy low, ready high; pulled high when floating) |

## Verification
The bench builds the block with ADDR_W = 8, DATA_W = 16, `clk_div` = 2 and `poll_gap` = 40. At these values each frame takes about a hundred clocks, and a busy time of a few hundred clocks gives several suspended retries. TMO_CYC is lowered to 3000, so a device model that stays busy for 4000 clocks reaches the timeout path in a short run. The model captures every frame bit on the rising serial clock, so the unlock-before-first-write sequence and each command encoding are compared bit for bit.

// File: rtl/eep_pkg.sv
// Shared types for the serial EEPROM write controller.
// Assumes: command codes 0..3 come from the requester; 4 is internal only.
package eep_pkg;

    typedef enum logic [2:0] {
        CMD_WRITE  = 3'd0,
        CMD_ERASE  = 3'd1,
        CMD_FILL   = 3'd2,
        CMD_WIPE   = 3'd3,
        CMD_UNLOCK = 3'd4
    } eep_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SHIFT,
        ST_SETTLE,
        ST_POLL,
        ST_PWAIT
    } eep_state_e;

endpackage

// File: rtl/eep_sk_gen.sv
// Half-period timer and serial clock generator.
// tick pulses once every div clocks while run is high. clr restarts the
// count, so a segment that begins with clr lasts div+1 clocks.
// sk toggles on tick only while toggle_en is high, and rests low otherwise.
// Assumes div >= 1.
module eep_sk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             toggle_en,
    input  logic [DIV_W-1:0] div,
    output logic             sk,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && !clr && (cnt == div - DIV_W'(1));

    // Count clocks within a half period and toggle the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sk  <= 1'b0;
        end else begin
            if (!run || clr || tick) cnt <= '0;
            else                     cnt <= cnt + DIV_W'(1);
            if (!toggle_en) sk <= 1'b0;
            else if (tick)  sk <= ~sk;
        end
    end

    // R4: the serial clock only rises while toggling is enabled
    a_r4_sk_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sk) |-> $past(toggle_en));

endmodule

// File: rtl/eep_frame_build.sv
// Builds the command frame, left-aligned at the MSB, together with its
// length in bits. Assumes ADDR_W >= 3 so that the two sub-op bits of the
// array-wide commands fit inside the address field.
module eep_frame_build
    import eep_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 3 + ADDR_W + DATA_W,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  eep_cmd_e            cmd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    output logic [FRAME_W-1:0]  frame,
    output logic [LEN_W-1:0]    len
);

    localparam int HDR_W = 3 + ADDR_W;
    localparam logic [ADDR_W-3:0] PADZ = '0;
    localparam logic [DATA_W-1:0] DATZ = '0;

    // Select the opcode, address field and data part for the command.
    always_comb begin
        unique case (cmd)
            CMD_WRITE: begin
                frame = {1'b1, 2'b01, addr, data};
                len   = LEN_W'(FRAME_W);
            end
            CMD_ERASE: begin
                frame = {1'b1, 2'b11, addr, DATZ};
                len   = LEN_W'(HDR_W);
            end
            CMD_FILL: begin
                frame = {1'b1, 2'b00, 2'b01, PADZ, data};
                len   = LEN_W'(FRAME_W);
            end
            CMD_WIPE: begin
                frame = {1'b1, 2'b00, 2'b10, PADZ, DATZ};
                len   = LEN_W'(HDR_W);
            end
            default: begin
                frame = {1'b1, 2'b00, 2'b11, PADZ, DATZ};
                len   = LEN_W'(HDR_W);
            end
        endcase
    end

endmodule

// File: rtl/eep_timeout.sv
// Write-time watchdog. It counts clocks while en is high and raises expired
// in the LIMIT-th clock. The count clears as soon as en drops.
module eep_timeout #(
    parameter int LIMIT = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = en && (cnt == CW'(LIMIT - 1));

    // Count the clocks elapsed since the commit.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!en)      cnt <= '0;
        else if (!expired) cnt <= cnt + CW'(1);
    end

    // R11: the count never passes the limit
    a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < CW'(LIMIT)));

endmodule

// File: rtl/eep_wr_ctrl.sv
// Host-side write-and-poll controller for a 3-wire serial EEPROM.
// Sequence per request: a chip-select-low gap, an optional unlock frame and
// gap, the command frame, the commit (CS low), then verify: raise CS with DI
// and SK low and sample DO until it reads high, or until TMO_CYC clocks have
// passed since the commit.
// Assumes eep_do is synchronous to clk (or synchronised outside) and that
// clk_div >= 1.
module eep_wr_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int DIV_W   = 8,
    parameter int GAP_W   = 16,
    parameter int TMO_CYC = 400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              poll_suspend,
    input  logic [GAP_W-1:0]  poll_gap,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              eep_cs,
    output logic              eep_sk,
    output logic              eep_di,
    input  logic              eep_do
);

    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    eep_state_e         state, state_prev, gap_to;
    eep_cmd_e           op_q, build_cmd;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [FRAME_W-1:0] shreg, frame;
    logic [LEN_W-1:0]   bitcnt, frame_len;
    logic [GAP_W-1:0]   pw_cnt;
    logic               half, send_unlock, unlocked, verifying;
    logic               busy_q, done_q, tmo_q, cs_q;
    logic               tick, tmo_exp, seg_clr;

    assign seg_clr   = (state != state_prev);
    assign build_cmd = send_unlock ? CMD_UNLOCK : op_q;

    eep_sk_gen #(.DIV_W(DIV_W)) u_sk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state != ST_IDLE),
        .clr       (seg_clr),
        .toggle_en (state == ST_SHIFT),
        .div       (clk_div),
        .sk        (eep_sk),
        .tick      (tick)
    );

    eep_frame_build #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .cmd   (build_cmd),
        .addr  (addr_q),
        .data  (data_q),
        .frame (frame),
        .len   (frame_len)
    );

    eep_timeout #(.LIMIT(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (verifying),
        .expired (tmo_exp)
    );

    assign busy    = busy_q;
    assign done    = done_q;
    assign timeout = tmo_q;
    assign eep_cs  = cs_q;
    assign eep_di  = (state == ST_SHIFT) ? shreg[FRAME_W-1] : 1'b0;

    // Request sequencing: frame shifting, commit, verify and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            state_prev  <= ST_IDLE;
            gap_to      <= ST_SHIFT;
            op_q        <= CMD_WRITE;
            addr_q      <= '0;
            data_q      <= '0;
            shreg       <= '0;
            bitcnt      <= '0;
            pw_cnt      <= '0;
            half        <= 1'b0;
            send_unlock <= 1'b0;
            unlocked    <= 1'b0;
            verifying   <= 1'b0;
            busy_q      <= 1'b0;
            done_q      <= 1'b0;
            tmo_q       <= 1'b0;
            cs_q        <= 1'b0;
        end else begin
            state_prev <= state;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
            if (verifying && tmo_exp) begin
                cs_q      <= 1'b0;
                verifying <= 1'b0;
                busy_q    <= 1'b0;
                tmo_q     <= 1'b1;
                state     <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (req_valid) begin
                            op_q        <= eep_cmd_e'(req_op);
                            addr_q      <= req_addr;
                            data_q      <= req_data;
                            busy_q      <= 1'b1;
                            send_unlock <= !unlocked;
                            gap_to      <= ST_SHIFT;
                            half        <= 1'b0;
                            state       <= ST_GAP;
                        end
                    end
                    ST_GAP: begin
                        if (tick) begin
                            if (half) begin
                                half <= 1'b0;
                                cs_q <= 1'b1;
                                if (gap_to == ST_SHIFT) begin
                                    shreg  <= frame;
                                    bitcnt <= frame_len;
                                    state  <= ST_SHIFT;
                                end else begin
                                    state  <= ST_SETTLE;
                                end
                            end else begin
                                half <= 1'b1;
                            end
                        end
                    end
                    ST_SHIFT: begin
                        if (tick && eep_sk) begin
                            if (bitcnt == LEN_W'(1)) begin
                                cs_q  <= 1'b0;
                                half  <= 1'b0;
                                state <= ST_GAP;
                                if (send_unlock) begin
                                    unlocked    <= 1'b1;
                                    send_unlock <= 1'b0;
                                    gap_to      <= ST_SHIFT;
                                end else begin
                                    verifying <= 1'b1;
                                    gap_to    <= ST_SETTLE;
                                end
                            end else begin
                                shreg  <= {shreg[FRAME_W-2:0], 1'b0};
                                bitcnt <= bitcnt - LEN_W'(1);
                            end
                        end
                    end
                    ST_SETTLE: begin
                        if (tick) begin
                            if (eep_do) begin
                                cs_q      <= 1'b0;
                                verifying <= 1'b0;
                                busy_q    <= 1'b0;
                                done_q    <= 1'b1;
                                state     <= ST_IDLE;
                            end else if (!poll_suspend) begin
                                state <= ST_POLL;
                            end else begin
                                cs_q   <= 1'b0;
                                pw_cnt <= poll_gap;
                                state  <= ST_PWAIT;
                            end
                        end
                    end
                    ST_POLL: begin
                        if (eep_do) begin
                            cs_q      <= 1'b0;
                            verifying <= 1'b0;
                            busy_q    <= 1'b0;
                            done_q    <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end
                    ST_PWAIT: begin
                        if (pw_cnt == '0) begin
                            half   <= 1'b0;
                            gap_to <= ST_SETTLE;
                            state  <= ST_GAP;
                        end else begin
                            pw_cnt <= pw_cnt - GAP_W'(1);
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R7: DI and SK stay low while CS is high during verify
    a_r7_quiet_verify: assert property (@(posedge clk) disable iff (!rst_n)
        (verifying && cs_q) |-> (!eep_di && !eep_sk));

    // R4: DI is steady at each rising serial clock
    a_r4_di_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eep_sk) |-> $stable(eep_di));

    // R6: the serial clock is low when CS falls
    a_r6_commit_sk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_q) |-> !eep_sk);

    // R10: done is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2: busy is low in the completion cycle
    a_r2_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q || tmo_q) |-> !busy_q);

    // R11: done and timeout never pulse together
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && tmo_q));

    // R12: the latched request holds while busy
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));

endmodule

// File: tb/tb_eep_wr_ctrl.sv
// Bench: a behavioural EEPROM model captures frames and models the busy time.
// A vector table drives the main loop; directed tests cover reset and the
// ignored request.
module tb_eep_wr_ctrl;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int DIV    = 2;
    localparam int GAP    = 40;
    localparam int TMO    = 3000;
    localparam logic [31:0] UNLOCK_FRAME = 32'b100_11_000000;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [15:0] data;
        logic        susp;
        logic [15:0] busyc;
        logic        exp_tmo;
        logic [3:0]  min_empty;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{3'd0, 8'hA5, 16'h1234, 1'b0, 16'd120,  1'b0, 4'd1},
        '{3'd1, 8'h3C, 16'h0000, 1'b1, 16'd300,  1'b0, 4'd2},
        '{3'd2, 8'h00, 16'hBEEF, 1'b1, 16'd60,   1'b0, 4'd1},
        '{3'd3, 8'h00, 16'h0000, 1'b0, 16'd200,  1'b0, 4'd1},
        '{3'd0, 8'hFF, 16'h8001, 1'b1, 16'd900,  1'b0, 4'd3},
        '{3'd1, 8'h00, 16'h0000, 1'b0, 16'd4000, 1'b1, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [7:0] clk_div = 8'(DIV);
    logic poll_suspend = 1'b0;
    logic [15:0] poll_gap = 16'(GAP);
    logic busy, done, timeout, eep_cs, eep_sk, eep_di, eep_do;

    always #10 clk = ~clk;

    eep_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(8), .GAP_W(16), .TMO_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .clk_div(clk_div),
        .poll_suspend(poll_suspend), .poll_gap(poll_gap), .busy(busy),
        .done(done), .timeout(timeout), .eep_cs(eep_cs), .eep_sk(eep_sk),
        .eep_di(eep_di), .eep_do(eep_do)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Device model and line monitors.
    logic        cs_q = 1'b0, sk_q = 1'b0, di_q = 1'b0, seen_cs = 1'b0;
    logic [31:0] rx = '0, last_frame = '0, prev_frame = '0;
    int          rxcnt = 0, last_len = 0, frames = 0, empty_cnt = 0;
    int          busy_cnt = 0, busy_cfg = 0, hcnt = 0, lcnt = 0;
    int          r4_bad = 0, r6_bad = 0, r7_bad = 0;
    bit          in_verify = 1'b0;

    assign eep_do = !(eep_cs && busy_cnt != 0);

    always @(posedge clk) begin
        cs_q <= eep_cs;
        sk_q <= eep_sk;
        di_q <= eep_di;
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (done || timeout) in_verify <= 1'b0;
        if (eep_cs && eep_sk && !sk_q) begin
            rx    <= {rx[30:0], eep_di};
            rxcnt <= rxcnt + 1;
        end
        if (eep_sk && !sk_q && eep_di != di_q) r4_bad <= r4_bad + 1;
        if (eep_sk) hcnt <= hcnt + 1;
        if (!eep_sk && sk_q) begin
            if (hcnt != DIV) r4_bad <= r4_bad + 1;
            hcnt <= 0;
        end
        if (!eep_cs) lcnt <= lcnt + 1;
        if (eep_cs && !cs_q) begin
            if (seen_cs && lcnt < 2 * DIV) r6_bad <= r6_bad + 1;
            seen_cs <= 1'b1;
            lcnt <= 0;
        end
        if (in_verify && eep_cs && (eep_di || eep_sk)) r7_bad <= r7_bad + 1;
        if (!eep_cs && cs_q) begin
            if (eep_sk) r6_bad <= r6_bad + 1;
            if (rxcnt == 0) begin
                empty_cnt <= empty_cnt + 1;
            end else begin
                prev_frame <= last_frame;
                last_frame <= rx;
                last_len   <= rxcnt;
                frames     <= frames + 1;
                if (rx != UNLOCK_FRAME) begin
                    busy_cnt  <= busy_cfg;
                    in_verify <= 1'b1;
                end
            end
            rx    <= '0;
            rxcnt <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected frame from the R3 encodings, right-aligned.
    function automatic logic [31:0] exp_frame(input logic [2:0] op,
            input logic [7:0] a, input logic [15:0] d, output int len);
        case (op)
            3'd0: begin len = 27; exp_frame = {5'b0, 3'b101, a, d}; end
            3'd1: begin len = 11; exp_frame = {21'b0, 3'b111, a}; end
            3'd2: begin len = 27; exp_frame = {5'b0, 3'b100, 2'b01, 6'b0, d}; end
            default: begin len = 11; exp_frame = {21'b0, 3'b100, 2'b10, 6'b0}; end
        endcase
    endfunction

    task automatic issue(input logic [2:0] op, input logic [7:0] a,
                         input logic [15:0] d, input logic susp);
        @(negedge clk);
        req_op = op; req_addr = a; req_data = d; poll_suspend = susp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_tmo);
        got_done = 1'b0; got_tmo = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done)    begin got_done = 1'b1; break; end
            if (timeout) begin got_tmo  = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit gd, gt;
        int elen, f0, e0;
        logic [31:0] ef;
        // R1: reset state
        repeat (3) @(negedge clk);
        check({eep_cs, eep_sk, eep_di, busy, done, timeout} == 6'b0, "R1",
              "outputs in reset", {eep_cs, eep_sk, eep_di, busy, done, timeout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({eep_cs, eep_sk, eep_di, busy, done, timeout} == 6'b0, "R1",
              "outputs after reset", {eep_cs, eep_sk, eep_di, busy, done, timeout}, 0);

        for (int v = 0; v < 6; v++) begin
            f0 = frames; e0 = empty_cnt;
            busy_cfg = int'(VECS[v].busyc);
            issue(VECS[v].op, VECS[v].addr, VECS[v].data, VECS[v].susp);
            check(busy == 1'b1, "R2", "busy after accept", busy, 1);
            wait_end(gd, gt);
            check(gd == !VECS[v].exp_tmo, "R10", "done seen", gd, !VECS[v].exp_tmo);
            check(gt == VECS[v].exp_tmo, "R11", "timeout seen", gt, VECS[v].exp_tmo);
            check(busy == 1'b0, "R2", "busy in completion cycle", busy, 0);
            @(negedge clk);
            check(!done && !timeout, "R10", "pulse width one", {done, timeout}, 0);
            check(!eep_cs, "R11", "cs low after end", eep_cs, 0);
            ef = exp_frame(VECS[v].op, VECS[v].addr, VECS[v].data, elen);
            check(last_frame == ef && last_len == elen, "R3", "frame bits",
                  last_frame, ef);
            if (v == 0) begin
                check(frames - f0 == 2, "R5", "unlock plus command", frames - f0, 2);
                check(prev_frame == UNLOCK_FRAME, "R5", "unlock frame", prev_frame,
                      UNLOCK_FRAME);
            end else begin
                check(frames - f0 == 1, "R5", "command only", frames - f0, 1);
            end
            if (!VECS[v].susp)
                check(empty_cnt - e0 == 1, "R8", "single verify interval",
                      empty_cnt - e0, 1);
            else
                check(empty_cnt - e0 >= int'(VECS[v].min_empty), "R9",
                      "suspended retries", empty_cnt - e0, VECS[v].min_empty);
            repeat (10) @(negedge clk);
        end

        // R12: a request raised while busy is ignored
        repeat (1500) @(negedge clk);
        f0 = frames;
        busy_cfg = 400;
        issue(3'd0, 8'h5A, 16'hC3C3, 1'b0);
        repeat (50) @(negedge clk);
        req_op = 3'd3; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_end(gd, gt);
        check(gd, "R12", "done for first request", gd, 1);
        repeat (300) @(negedge clk);
        check(frames - f0 == 1, "R12", "frames sent", frames - f0, 1);
        ef = exp_frame(3'd0, 8'h5A, 16'hC3C3, elen);
        check(last_frame == ef, "R12", "latched request kept", last_frame, ef);
        check(!busy, "R12", "stays idle", busy, 0);

        check(r4_bad == 0, "R4", "sk timing / di hold violations", r4_bad, 0);
        check(r6_bad == 0, "R6", "cs gap / sk at commit violations", r6_bad, 0);
        check(r7_bad == 0, "R7", "di or sk high in verify", r7_bad, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule